// File: doc/BRIEF.md
# Sticky Supply-Event Status Register

This block holds two sticky event flags that a supply monitor raises. One flag records that the supply dropped under its low threshold. The other records that it climbed over its high threshold. Both indications come from comparators outside the block as digital levels, and each passes through a two-flop synchronizer before it can set its flag.

A CPU-style bus reads and writes the flags through one 8-bit register. The bus has a register select, a read strobe, a write strobe and write data. A flag clears only through a handshake: software must first see the flag as 1 in a read, and then write 0 to that bit. Each flag keeps its own arm bit to remember that read. This stops software from clearing an event it has never observed.

Top module: `vmonStatusReg`

## Requirements
- R1: After reset the register reads as 8'hFC, and `rdData` holds 8'hFC before any read.
- R2: Bits 7 to 2 of every read are 1, and writing any value to them has no effect.
- R3: Bit 1 is the under-voltage flag. A high level on `underIn` at clock edge n sets the flag at edge n+2. A read presented at edge n+3 returns the flag as 1, and a read at edge n+2 still returns 0.
- R4: Bit 0 is the over-voltage flag. `overIn` sets it with the same synchronizer timing as R3.
- R5: A read (`selIn` and `rdEn` high at an edge) loads `rdData` with {6'b111111, under, over} at that edge. `rdData` keeps its value in every cycle without a read.
- R6: A read that returns a flag as 1 arms that flag. A later write with that bit at 0 clears the flag at the write edge and disarms it.
- R7: Writing 0 to a flag that is not armed leaves it unchanged. Writing 1 to a flag never sets it and never clears it.
- R8: When a set level and a valid clearing write occur in the same cycle, the flag stays 1. The arm bit is still consumed, so a fresh read is needed before the next clear.
- R9: A flag stays 1 after its input returns low, until a valid clearing write.
- R10: The two flags arm and clear independently. A write clears only the armed flags whose bits are 0.
- R11: With `selIn` low, read and write strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| underIn | input | 1 | Under-threshold comparator level |
| overIn | input | 1 | Over-threshold comparator level |
| selIn | input | 1 | Register select |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |

## Verification
Read data is due one edge after the read strobe, so the monitor compares `rdData` at the falling edge that follows the edge that takes the read. A comparator level sets its flag two edges after it is first sampled, so a read shows the flag only from the third edge onward. The bench waits out that third edge, and at one point it reads on the edge before it to show the delay. A clearing write acts at its own edge, so the bench issues the read that checks a clear in the very next cycle.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
  localparam int FLAG_N = 2;

  typedef struct packed {
    logic              rdStrobe;
    logic              wrStrobe;
    logic [FLAG_N-1:0] clrBits;
  } busCmd_t;
endpackage

// File: rtl/vmonSync.sv
module vmonSync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       stageQ[s] <= '0;
        else if (s == 0) stageQ[s] <= asyncIn;
        else             stageQ[s] <= stageQ[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

  genvar b;
  generate
    if (STAGES == 2) begin : g_chk
      for (b = 0; b < WIDTH; b++) begin : g_bit
        // R3: a rise at the output reflects the input two edges earlier
        p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rstN)
          $rose(syncOut[b]) |-> $past(asyncIn[b], 2));
      end
    end
  endgenerate
endmodule

// File: rtl/vmonCtrl.sv
module vmonCtrl
  import vmon_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             selIn,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output busCmd_t          cmd
);
  logic wrHit;

  always_comb begin
    wrHit        = selIn && wrEn;
    cmd.rdStrobe = selIn && rdEn;
    cmd.wrStrobe = wrHit;
    // only zero bits in the flag field request a clear; bits above it are dropped
    cmd.clrBits  = wrHit ? ~wrData[FLAG_N-1:0] : '0;
  end
endmodule

// File: rtl/vmonDatapath.sv
module vmonDatapath
  import vmon_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_N-1:0] setLevel,
  input  busCmd_t           cmd,
  output logic [REG_W-1:0]  rdData
);
  localparam int PAD_W = REG_W - FLAG_N;
  localparam logic [REG_W-1:0] RD_RESET = {{PAD_W{1'b1}}, {FLAG_N{1'b0}}};

  logic [FLAG_N-1:0] flagQ;
  logic [FLAG_N-1:0] armQ;

  genvar i;
  generate
    for (i = 0; i < FLAG_N; i++) begin : g_flag
      logic clrOk;
      assign clrOk = cmd.clrBits[i] && armQ[i];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagQ[i] <= 1'b0;
          armQ[i]  <= 1'b0;
        end else begin
          flagQ[i] <= setLevel[i] || (flagQ[i] && !clrOk);
          if (clrOk)                          armQ[i] <= 1'b0;
          else if (cmd.rdStrobe && flagQ[i])  armQ[i] <= 1'b1;
        end
      end

      // R6: an arm bit never exists without its flag
      p_arm_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
        armQ[i] |-> flagQ[i]);
      // R6: a flag only falls when it was armed
      p_clear_armed_r6: assert property (@(posedge clk) disable iff (!rstN)
        $fell(flagQ[i]) |-> $past(armQ[i]));
      // R7: an unarmed flag holds
      p_unarmed_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
        (flagQ[i] && !armQ[i]) |=> flagQ[i]);
      // R8: a set level wins over any clear
      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
        setLevel[i] |=> flagQ[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= RD_RESET;
    else if (cmd.rdStrobe) rdData <= {{PAD_W{1'b1}}, flagQ};
  end

  // R5: read data moves only after a read strobe
  p_read_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.rdStrobe |=> $stable(rdData));
endmodule

// File: rtl/vmonStatusReg.sv
module vmonStatusReg
  import vmon_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             underIn,
  input  logic             overIn,
  input  logic             selIn,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData
);
  logic [FLAG_N-1:0] setLevel;
  busCmd_t           cmd;

  vmonSync #(.STAGES(SYNC_STAGES), .WIDTH(FLAG_N)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({underIn, overIn}), .syncOut(setLevel));

  vmonCtrl #(.REG_W(REG_W)) u_ctrl (
    .selIn(selIn), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .cmd(cmd));

  vmonDatapath #(.REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .setLevel(setLevel), .cmd(cmd), .rdData(rdData));
endmodule

// File: tb/vmonStatusReg_tb.sv
`timescale 1ns/1ps
module vmonStatusReg_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic underIn = 1'b0, overIn = 1'b0;
  logic selIn = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [7:0] expQ [$];
  string      tagQ [$];

  always #2.5 clk = ~clk;

  vmonStatusReg u_dut (.clk(clk), .rstN(rstN), .underIn(underIn), .overIn(overIn),
    .selIn(selIn), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdReg(input logic [7:0] exp, input string tag);
    selIn = 1'b1; rdEn = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    selIn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] d, input logic sel);
    selIn = sel; wrEn = 1'b1; wrData = d;
    @(negedge clk);
    selIn = 1'b0; wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic pulseUnder;
    underIn = 1'b1; @(negedge clk); underIn = 1'b0;
  endtask

  task automatic pulseOver;
    overIn = 1'b1; @(negedge clk); overIn = 1'b0;
  endtask

  // monitor: a read accepted at an edge is compared at the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (selIn && rdEn) begin
        @(negedge clk);
        check(rdData, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(rdData, 8'hFC, "R1 rdData at reset");
    rstN = 1'b1;
    idle(1);
    rdReg(8'hFC, "R1 first read");
    wrReg(8'hFF, 1'b1);
    rdReg(8'hFC, "R2 upper bits and write-1 ignored");
    wrReg(8'h00, 1'b1);
    rdReg(8'hFC, "R7 zero write with nothing armed");
    // R3 latency
    pulseUnder();
    rdReg(8'hFC, "R3 not yet at edge n+1");
    rdReg(8'hFC, "R3 not yet at edge n+2");
    rdReg(8'hFE, "R3 under flag at edge n+3");
    underIn = 1'b0;
    idle(3);
    rdReg(8'hFE, "R9 sticky after input low");
    wrReg(8'hFD, 1'b1);
    rdReg(8'hFC, "R6 armed clear");
    // R4 / R10
    pulseOver(); idle(2);
    rdReg(8'hFD, "R4 over flag");
    pulseUnder(); idle(2);
    wrReg(8'h00, 1'b1);
    rdReg(8'hFE, "R10 only armed over cleared, R7 unarmed under kept");
    wrReg(8'h00, 1'b1);
    rdReg(8'hFC, "R10 under cleared after its own read");
    // R8 set wins
    underIn = 1'b1; idle(3);
    rdReg(8'hFE, "R8 setup");
    wrReg(8'h00, 1'b1);
    rdReg(8'hFE, "R8 set wins over clear");
    underIn = 1'b0; idle(3);
    // the read above re-armed under; clear it and verify
    wrReg(8'h00, 1'b1);
    rdReg(8'hFC, "R8 clear after re-read");
    underIn = 1'b1; idle(3);
    rdReg(8'hFE, "R8 re-setup");
    wrReg(8'h00, 1'b1);
    underIn = 1'b0; idle(3);
    wrReg(8'h00, 1'b1);
    rdReg(8'hFE, "R8 arm consumed by overridden clear");
    wrReg(8'h00, 1'b1);
    rdReg(8'hFC, "R6 clear after fresh read");
    // R11 select gating
    pulseOver(); idle(2);
    rdReg(8'hFD, "R11 setup");
    wrReg(8'h00, 1'b0);
    rdReg(8'hFD, "R11 unselected write ignored");
    selIn = 1'b0; rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
    check(rdData, 8'hFD, "R11 unselected read leaves rdData");
    wrReg(8'h00, 1'b1);
    idle(1);
    check(rdData, 8'hFD, "R5 rdData holds without read");
    rdReg(8'hFC, "R11 selected clear");
    // R7 write-1 keeps armed flag
    pulseOver(); idle(2);
    rdReg(8'hFD, "R7 setup");
    wrReg(8'h01, 1'b1);
    rdReg(8'hFD, "R7 write 1 does not clear");
    wrReg(8'hFC, 1'b1);
    rdReg(8'hFC, "R2 upper write bits ignored, R6 clear");
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule